// File: doc/BRIEF.md
# DMA Channel Descriptor Control

This block is the control path for one channel of a peripheral DMA engine. It holds the channel's control word, which software writes and a descriptor fetch can replace. It also holds the channel status: enabled, active, and three sticky event flags. A small state machine decides when the channel moves data, when it empties its FIFO, and when it asks for the next transfer descriptor. The data path, the FIFO storage and descriptor memory sit outside. They see this block only through a per-byte beat strobe, a drain command, an empty flag and a fetch handshake.

Software starts the channel by writing the enable bit together with a byte count. While the channel is enabled, every cycle with a pending request moves one byte, and the count drops by one. There are three ways the run stops: the count reaches zero, the peripheral signals end of transfer, or software clears the enable. When software disables the channel during a transfer, the FIFO is emptied before the enabled status drops. A chain bit in the control word makes the channel fetch its next descriptor when a transfer ends. The same bit lets it skip the loaded descriptor when software disables the channel.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the control word is zero and every status output is low: stat_en, stat_act, the three sticky flags, irq, drain_cmd, desc_ld_req and xfer_beat.
- R2: Control word fields are placed as follows: bit 0 enable, bit 1 chain (fetch next descriptor), bit 2 end-of-transfer enable, bit 3 end-of-buffer enable, bit 4 end-of-transfer interrupt enable, bit 5 end-of-buffer interrupt enable, bit 6 descriptor-loaded interrupt enable, bit 7 burst lock, bits 31:16 byte count. A write while no fetch is pending appears on ctl_word one cycle later.
- R3: A write with bit 0 set to a stopped channel raises stat_en one cycle later. While the channel is enabled, xfer_beat is high in the same cycle as xfer_req, provided the count is nonzero and no write is present. In that case the count falls by one and stat_act is set one cycle later.
- R4: A write that clears bit 0 while stat_act is high starts a drain. From the next cycle drain_cmd is high, and stat_en and stat_act stay high until fifo_empty is seen during the drain. All three drop one cycle after that.
- R5: A beat that brings the count to zero clears control bit 0, drops stat_en and stat_act, and sets stat_eob, all one cycle later.
- R6: When eot_in is high while the channel is enabled and bit 2 is set, the run ends one cycle later. Control bit 0, stat_en and stat_act drop, and stat_eot is set.
- R7: When a run ends (R5, R6 or a finished drain) with bit 1 set, desc_ld_req rises one cycle later. With bit 1 clear, the channel stops and makes no request. desc_ld_req and stat_en are never high together.
- R8: A write that clears bit 0 and sets bit 1 to a channel that is not moving data skips the loaded descriptor. desc_ld_req rises one cycle later and no beat occurs in the write cycle.
- R9: A stopped channel whose control word holds bit 0 clear and bit 1 set raises desc_ld_req one cycle after any xfer_req.
- R10: desc_ld_done during a request loads desc_word into ctl_word, sets stat_dld and drops desc_ld_req, one cycle later. The channel runs if bit 0 of the new word is set. Otherwise it stays stopped, and requests are ignored unless bit 1 is set.
- R11: Writes while desc_ld_req is high and desc_ld_done is low leave ctl_word unchanged.
- R12: rd_stat clears the three sticky flags one cycle later. An event in the same cycle keeps its flag set.
- R13: irq is high exactly when some sticky flag is set together with its interrupt enable: stat_dld with bit 6, stat_eob with bit 5, stat_eot with bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for the control word |
| wr_data | input | CTL_W | Control word value to write |
| rd_stat | input | 1 | Status read strobe, clears sticky flags |
| xfer_req | input | 1 | Peripheral transfer request |
| eot_in | input | 1 | Peripheral end-of-transfer indication |
| fifo_empty | input | 1 | Channel FIFO holds no data |
| desc_ld_done | input | 1 | Descriptor fetch finished, desc_word valid |
| desc_word | input | CTL_W | Control word carried by the fetched descriptor |
| ctl_word | output | CTL_W | Current control word |
| stat_en | output | 1 | Channel enabled status |
| stat_act | output | 1 | Channel active status |
| stat_dld | output | 1 | Sticky descriptor-loaded flag |
| stat_eob | output | 1 | Sticky end-of-buffer flag |
| stat_eot | output | 1 | Sticky end-of-transfer flag |
| irq | output | 1 | Channel interrupt |
| xfer_beat | output | 1 | One byte moves this cycle |
| drain_cmd | output | 1 | Command to empty the FIFO |
| desc_ld_req | output | 1 | Request to fetch the next descriptor |

## Verification
xfer_beat is the only combinational result. It is sampled one time unit after the inputs change and before the clock edge. Every other result — status, control word, drain and fetch request, and irq, which follows registered flags — is due exactly one clock edge after the stimulus cycle. Inputs are applied a quarter period after a rising edge, and outputs are read a quarter period after the next one. A drain lasts as long as the bench holds fifo_empty low. So the bench samples every cycle of a held drain, and checks the drop on the edge after fifo_empty rises.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int F_EN      = 0;
  localparam int F_CHAIN   = 1;
  localparam int F_EOT_EN  = 2;
  localparam int F_EOB_EN  = 3;
  localparam int F_IE_EOT  = 4;
  localparam int F_IE_EOB  = 5;
  localparam int F_IE_DLD  = 6;
  localparam int F_BURST   = 7;
  localparam int LEN_LSB   = 16;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2,
    CH_FETCH = 2'd3
  } ch_state_e;

  // flags and enables ordered {dld, eob, eot}
  function automatic logic irq_merge(input logic [2:0] flags, input logic [2:0] ie);
    return |(flags & ie);
  endfunction

endpackage

// File: rtl/dma_chan_ctlreg.sv
module dma_chan_ctlreg
  import dma_chan_pkg::*;
#(
  parameter  int LEN_W = 16,
  localparam int CTL_W = LEN_LSB + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_desc,
  input  logic [CTL_W-1:0] desc_word,
  input  logic             sw_wr,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             force_off,
  input  logic             beat,
  input  logic             clr_en,
  output logic [CTL_W-1:0] ctl_q
);

  function automatic logic [LEN_W-1:0] len_dec(input logic [LEN_W-1:0] len);
    return len - LEN_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ld_desc) begin
      ctl_q <= desc_word;
    end else if (sw_wr) begin
      ctl_q <= wr_data;
      if (force_off) ctl_q[F_EN] <= 1'b0;
    end else begin
      if (beat)   ctl_q[CTL_W-1:LEN_LSB] <= len_dec(ctl_q[CTL_W-1:LEN_LSB]);
      if (clr_en) ctl_q[F_EN] <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_start,
  input  logic      idle_fetch,
  input  logic      sw_off,
  input  logic      wr_chain,
  input  logic      run_end,
  input  logic      beat,
  input  logic      drain_done,
  input  logic      fetch_done,
  input  logic      desc_en,
  input  logic      chain,
  output ch_state_e state,
  output logic      act
);

  ch_state_e state_d;
  logic      act_d;

  always_comb begin
    state_d = state;
    act_d   = act;
    unique case (state)
      CH_IDLE: begin
        if (idle_start)      state_d = CH_RUN;
        else if (idle_fetch) state_d = CH_FETCH;
      end
      CH_RUN: begin
        if (sw_off) begin
          if (act)           state_d = CH_DRAIN;
          else if (wr_chain) state_d = CH_FETCH;
          else               state_d = CH_IDLE;
        end else if (run_end) begin
          state_d = chain ? CH_FETCH : CH_IDLE;
          act_d   = 1'b0;
        end else if (beat) begin
          act_d   = 1'b1;
        end
      end
      CH_DRAIN: begin
        if (drain_done) begin
          state_d = chain ? CH_FETCH : CH_IDLE;
          act_d   = 1'b0;
        end
      end
      CH_FETCH: begin
        if (fetch_done) state_d = desc_en ? CH_RUN : CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      act   <= 1'b0;
    end else begin
      state <= state_d;
      act   <= act_d;
    end
  end

endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_dld,
  input  logic       set_eob,
  input  logic       set_eot,
  input  logic       rd_clr,
  input  logic [2:0] ie,
  output logic [2:0] flags,
  output logic       irq
);

  logic [2:0] set_v;
  assign set_v = {set_dld, set_eob, set_eot};

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_v | (rd_clr ? 3'b000 : flags);
  end

  assign irq = irq_merge(flags, ie);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter  int LEN_W = 16,
  localparam int CTL_W = LEN_LSB + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             rd_stat,
  input  logic             xfer_req,
  input  logic             eot_in,
  input  logic             fifo_empty,
  input  logic             desc_ld_done,
  input  logic [CTL_W-1:0] desc_word,
  output logic [CTL_W-1:0] ctl_word,
  output logic             stat_en,
  output logic             stat_act,
  output logic             stat_dld,
  output logic             stat_eob,
  output logic             stat_eot,
  output logic             irq,
  output logic             xfer_beat,
  output logic             drain_cmd,
  output logic             desc_ld_req
);

  ch_state_e        state;
  logic             act;
  logic [2:0]       flags;
  logic [LEN_W-1:0] len;
  logic             in_idle, in_run, in_drain, in_fetch;

  // named internal events
  logic ev_beat, ev_eob, ev_eot, ev_run_end, ev_sw_off;
  logic ev_drain_done, ev_fetch_done, ev_idle_start, ev_idle_fetch, ev_sw_wr;

  assign len      = ctl_word[CTL_W-1:LEN_LSB];
  assign in_idle  = (state == CH_IDLE);
  assign in_run   = (state == CH_RUN);
  assign in_drain = (state == CH_DRAIN);
  assign in_fetch = (state == CH_FETCH);

  assign ev_sw_wr      = wr_en && !in_fetch;
  assign ev_beat       = in_run && !wr_en && xfer_req && (len != '0);
  assign ev_eob        = ev_beat && (len == LEN_W'(1));
  assign ev_eot        = in_run && !wr_en && eot_in && ctl_word[F_EOT_EN];
  assign ev_run_end    = ev_eob || ev_eot;
  assign ev_sw_off     = in_run && wr_en && !wr_data[F_EN];
  assign ev_drain_done = in_drain && fifo_empty;
  assign ev_fetch_done = in_fetch && desc_ld_done;
  assign ev_idle_start = in_idle && wr_en && wr_data[F_EN];
  assign ev_idle_fetch = in_idle &&
                         ((wr_en && !wr_data[F_EN] && wr_data[F_CHAIN]) ||
                          (!wr_en && xfer_req && ctl_word[F_CHAIN]));

  dma_chan_ctlreg #(.LEN_W(LEN_W)) u_ctlreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_desc   (ev_fetch_done),
    .desc_word (desc_word),
    .sw_wr     (ev_sw_wr),
    .wr_data   (wr_data),
    .force_off (in_drain),
    .beat      (ev_beat),
    .clr_en    (ev_run_end),
    .ctl_q     (ctl_word)
  );

  dma_chan_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_start (ev_idle_start),
    .idle_fetch (ev_idle_fetch),
    .sw_off     (ev_sw_off),
    .wr_chain   (wr_data[F_CHAIN]),
    .run_end    (ev_run_end),
    .beat       (ev_beat),
    .drain_done (ev_drain_done),
    .fetch_done (ev_fetch_done),
    .desc_en    (desc_word[F_EN]),
    .chain      (ctl_word[F_CHAIN]),
    .state      (state),
    .act        (act)
  );

  dma_chan_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_dld (ev_fetch_done),
    .set_eob (ev_eob),
    .set_eot (ev_eot),
    .rd_clr  (rd_stat),
    .ie      ({ctl_word[F_IE_DLD], ctl_word[F_IE_EOB], ctl_word[F_IE_EOT]}),
    .flags   (flags),
    .irq     (irq)
  );

  assign stat_en     = in_run || in_drain;
  assign stat_act    = act;
  assign stat_dld    = flags[2];
  assign stat_eob    = flags[1];
  assign stat_eot    = flags[0];
  assign xfer_beat   = ev_beat;
  assign drain_cmd   = in_drain;
  assign desc_ld_req = in_fetch;

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int CTL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CTL_W-1:0] wr_data,
  input logic             fifo_empty,
  input logic             desc_ld_done,
  input logic [CTL_W-1:0] desc_word,
  input logic [CTL_W-1:0] ctl_word,
  input logic             stat_en,
  input logic             stat_act,
  input logic             stat_eob,
  input logic             stat_dld,
  input logic             irq,
  input logic             drain_cmd,
  input logic             desc_ld_req,
  input logic             ev_eob
);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en && !desc_ld_req && wr_en && wr_data[0]) |=> stat_en);

  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_cmd && !fifo_empty) |=> (stat_en && stat_act));

  p_drain_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_cmd && fifo_empty) |=> (!stat_en && !stat_act && !drain_cmd));

  p_eob_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eob |=> (!stat_en && !ctl_word[0] && stat_eob));

  p_fetch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ld_req && stat_en));

  p_fetch_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_ld_req && desc_ld_done) |=> (ctl_word == $past(desc_word) && stat_dld && !desc_ld_req));

  p_fetch_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_ld_req && !desc_ld_done) |=> $stable(ctl_word));

  p_irq_dld_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_dld && ctl_word[6]) |-> irq);

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CTL_W(CTL_W)) u_chk (.*);

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;

  localparam int LEN_W = 16;
  localparam int CTL_W = 16 + LEN_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [CTL_W-1:0] wr_data = '0;
  logic             rd_stat = 1'b0;
  logic             xfer_req = 1'b0;
  logic             eot_in = 1'b0;
  logic             fifo_empty = 1'b1;
  logic             desc_ld_done = 1'b0;
  logic [CTL_W-1:0] desc_word = '0;
  logic [CTL_W-1:0] ctl_word;
  logic stat_en, stat_act, stat_dld, stat_eob, stat_eot, irq, xfer_beat, drain_cmd, desc_ld_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_chan_ctl #(.LEN_W(LEN_W)) dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        req;
    logic        fe;
    logic        en;
    logic        act;
    logic        drn;
    logic [15:0] len;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1, 32'h0003_0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd3},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2},
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1},
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
    '{1'b1, 32'h0004_0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3},
    '{1'b1, 32'h0003_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd3},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd3},
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  // inputs change 5 ns after a rising edge; outputs read 5 ns after the next one
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_data = '0; rd_stat = 1'b0; xfer_req = 1'b0;
    eot_in = 1'b0; desc_ld_done = 1'b0; fifo_empty = 1'b1;
  endtask

  task automatic write_word(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 ctl_word", ctl_word, 32'h0);
    chk("R1 status", {stat_en, stat_act, stat_dld, stat_eob, stat_eot, irq, drain_cmd, desc_ld_req, xfer_beat}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R3 R4 R5 table-driven run, end of buffer and drain
    for (int i = 0; i < 10; i++) begin
      wr_en = TBL[i].wr; wr_data = TBL[i].wd; xfer_req = TBL[i].req; fifo_empty = TBL[i].fe;
      tick();
      chk($sformatf("R3/R4/R5 row %0d en", i), {31'h0, stat_en}, {31'h0, TBL[i].en});
      chk($sformatf("R3/R4/R5 row %0d act", i), {31'h0, stat_act}, {31'h0, TBL[i].act});
      chk($sformatf("R4 row %0d drain", i), {31'h0, drain_cmd}, {31'h0, TBL[i].drn});
      chk($sformatf("R3/R5 row %0d len", i), {16'h0, ctl_word[31:16]}, {16'h0, TBL[i].len});
    end
    idle_inputs();
    chk("R5 eob sticky", {31'h0, stat_eob}, 32'h1);

    // R12 read clears sticky flag
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;
    chk("R12 eob cleared", {31'h0, stat_eob}, 32'h0);

    // R2 field placement, no start without bit 0
    write_word(32'hABCD_00F0);
    chk("R2 ctl_word", ctl_word, 32'hABCD_00F0);
    chk("R2 not enabled", {31'h0, stat_en}, 32'h0);

    // R3 combinational beat
    write_word(32'h0002_0001);
    xfer_req = 1'b1; #1;
    chk("R3 beat", {31'h0, xfer_beat}, 32'h1);
    tick(); tick(); xfer_req = 1'b0;
    // R13 irq from eob with bit 5 set? bit 5 clear here -> no irq
    chk("R13 irq masked", {31'h0, irq}, 32'h0);
    chk("R5 eob set", {31'h0, stat_eob}, 32'h1);
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;

    // R13 eob with interrupt enable
    write_word(32'h0002_0021);
    xfer_req = 1'b1; tick(); tick(); xfer_req = 1'b0;
    chk("R13 irq eob", {31'h0, irq}, 32'h1);
    // R12 set and clear in the same cycle keeps the flag
    write_word(32'h0001_0021);
    xfer_req = 1'b1; rd_stat = 1'b1; tick(); xfer_req = 1'b0; rd_stat = 1'b0;
    chk("R12 set wins", {31'h0, stat_eob}, 32'h1);
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;
    chk("R12/R13 irq cleared", {31'h0, irq}, 32'h0);

    // R6 end of transfer
    write_word(32'h0005_0005);
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    eot_in = 1'b1; tick(); eot_in = 1'b0;
    chk("R6 en/act", {30'h0, stat_en, stat_act}, 32'h0);
    chk("R6 eot flag", {31'h0, stat_eot}, 32'h1);
    chk("R6 ctl bit0", {31'h0, ctl_word[0]}, 32'h0);
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;

    // R7 chained end of buffer fetches next descriptor
    write_word(32'h0001_0003);
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    chk("R7 fetch req", {30'h0, desc_ld_req, stat_en}, 32'h2);

    // R11 writes ignored during fetch
    write_word(32'h00FF_0001);
    chk("R11 ctl unchanged", ctl_word, 32'h0000_0002);
    chk("R11 still fetching", {31'h0, desc_ld_req}, 32'h1);

    // R10 descriptor load starts the channel
    desc_word = 32'h0002_0041; desc_ld_done = 1'b1; tick(); desc_ld_done = 1'b0;
    chk("R10 ctl loaded", ctl_word, 32'h0002_0041);
    chk("R10 dld/en/req", {29'h0, stat_dld, stat_en, desc_ld_req}, 32'h6);
    chk("R13 irq dld", {31'h0, irq}, 32'h1);
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;

    // R8 skip: disable with chain while not moving data, no beat
    wr_en = 1'b1; wr_data = 32'h0000_0002; xfer_req = 1'b1; #1;
    chk("R8 no beat", {31'h0, xfer_beat}, 32'h0);
    tick(); wr_en = 1'b0; xfer_req = 1'b0;
    chk("R8 fetch req", {30'h0, desc_ld_req, stat_en}, 32'h2);

    // R10 frozen after descriptor with both bits clear
    desc_word = 32'h0; desc_ld_done = 1'b1; tick(); desc_ld_done = 1'b0;
    xfer_req = 1'b1; tick(); tick(); tick(); xfer_req = 1'b0;
    chk("R10 frozen", {30'h0, desc_ld_req, stat_en}, 32'h0);

    // R8 skip from a stopped channel, then R9 request-triggered fetch
    write_word(32'h0000_0002);
    chk("R8 idle skip", {31'h0, desc_ld_req}, 32'h1);
    desc_word = 32'h0000_0002; desc_ld_done = 1'b1; tick(); desc_ld_done = 1'b0;
    chk("R9 waiting", {30'h0, desc_ld_req, stat_en}, 32'h0);
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    chk("R9 fetch on request", {31'h0, desc_ld_req}, 32'h1);
    desc_word = 32'h0; desc_ld_done = 1'b1; tick(); desc_ld_done = 1'b0;

    // R7 chained drain: fetch once the FIFO empties
    write_word(32'h0004_0001);
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    fifo_empty = 1'b0;
    write_word(32'h0004_0002);
    chk("R4 draining", {29'h0, drain_cmd, stat_en, stat_act}, 32'h7);
    fifo_empty = 1'b1; tick();
    chk("R7 fetch after drain", {30'h0, desc_ld_req, stat_en}, 32'h2);
    desc_word = 32'h0; desc_ld_done = 1'b1; tick(); desc_ld_done = 1'b0;

    // R1 reset mid-run
    write_word(32'h0009_0001);
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    rst_n = 1'b0; tick();
    chk("R1 reset mid-run", {ctl_word[31:8], stat_en, stat_act, stat_dld, stat_eob, stat_eot, irq, drain_cmd, desc_ld_req}, 32'h0);
    rst_n = 1'b1; tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule